// File: doc/BRIEF.md
# Bit-Serial Arithmetic Logic Unit

This block is the function unit of a small 16-bit two's-complement datapath. It takes an accumulator word and an operand word and produces one result word and four condition flags: zero, overflow, negative and carry. Internally it is one bit wide. The two operand words shift past a single full-adder cell, least significant bit first, one bit per clock. A carry flip-flop links each bit position to the next.

A caller sets up the operands, the operation code and the chaining input, then pulses `start` while the unit is idle. The cycle that samples `start` loads the operands. Sixteen bit cycles follow, then one cycle that finalises the flags. `done` then pulses for one clock, with the new result and flags already valid. The result and flags hold until the next operation finishes.

When `chain_en` is set, the stored carry flag is fed back in. For add and subtract it becomes the carry into bit 0. For shifts it becomes the bit shifted in. This lets longer words be processed one 16-bit slice at a time.

Top module: `serial_alu`

## Requirements
- R1: `op` selects the operation: 0 add (a+b), 1 subtract (a-b), 2 AND, 3 OR, 4 exclusive-OR, 5 shift left one place, 6 shift right one place. Code 7 behaves as AND. `result` holds the 16-bit outcome.
- R2: `start` is sampled only when `busy` is low. `busy` goes high on the sampling edge. `done` rises on the 17th rising edge after the sampling edge, for exactly one cycle, and `busy` falls on that same edge.
- R3: After add or subtract, carry is the carry out of bit 15; for subtract, a set carry means no borrow. After a left shift, carry is the old bit 15. After a right shift, carry is the old bit 0.
- R4: After add or subtract, overflow reports signed two's-complement overflow. After either shift, overflow is set when the sign bit of the result differs from the sign bit of the operand.
- R5: After every operation, negative equals result bit 15, and zero is set exactly when all 16 result bits are 0.
- R6: With `chain_en` low, the carry-in is 0 for add and 1 for subtract. A left shift fills with 0, and a right shift fills with the old bit 15. With `chain_en` high, the stored carry flag is the carry-in for both add and subtract, and it is the fill bit for both shifts.
- R7: AND, OR and exclusive-OR (including code 7) leave the carry and overflow flags unchanged.
- R8: A `start` pulse while `busy` is high is ignored. `result` and all flags change only on the edge that raises `done`.
- R9: After reset, `result`, all flags, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 3 | Operation code (see R1) |
| acc_in | input | 16 | Accumulator operand (a) |
| opr_in | input | 16 | Second operand (b); unused by shifts |
| chain_en | input | 1 | Use the stored carry as carry-in or fill bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Result of the last completed operation |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |

## Verification
State inside the unit is visible only when `done` pulses, so every fault surfaces at a completion or at a missing completion. A bit-position counter that is off by one shows up as a `done` that comes early or late, or as a result shifted by one place, on the first operation. A carry flip-flop that is wrongly seeded or not cleared corrupts low result bits and the carry flag. This shows first on subtraction, or on any operation that follows a chained one. Overflow and zero faults stay hidden until an operand pair actually crosses the sign boundary or cancels to zero, so the stimulus deliberately includes such pairs.

// File: rtl/serial_alu_pkg.sv
package serial_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_SHL  = 3'd5,
        OP_SHR  = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic z;
        logic v;
        logic n;
        logic c;
    } flags_t;

    function automatic logic is_arith(alu_op_e o);
        return (o == OP_ADD) || (o == OP_SUB);
    endfunction

    function automatic logic is_shift(alu_op_e o);
        return (o == OP_SHL) || (o == OP_SHR);
    endfunction

endpackage

// File: rtl/serial_alu_seq.sv
module serial_alu_seq #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic run,
    output logic msb_bit,
    output logic fin,
    output logic busy,
    output logic done
);
    import serial_alu_pkg::*;

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          done;
    } seq_t;

    seq_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_RUN;
                    s_d.cnt   = '0;
                end
            end
            PH_RUN: begin
                s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt == LAST) s_d.phase = PH_FIN;
            end
            PH_FIN: begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.cnt   <= '0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign load    = start && (s_q.phase == PH_IDLE);
    assign run     = (s_q.phase == PH_RUN);
    assign msb_bit = run && (s_q.cnt == LAST);
    assign fin     = (s_q.phase == PH_FIN);
    assign busy    = (s_q.phase != PH_IDLE);
    assign done    = s_q.done;

endmodule

// File: rtl/serial_alu_bitcell.sv
module serial_alu_bitcell
    import serial_alu_pkg::*;
(
    input  alu_op_e op,
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    a_next,
    input  logic    a_prev,
    input  logic    cin,
    input  logic    msb_bit,
    input  logic    fill,
    output logic    r,
    output logic    cout
);
    logic b_eff;

    always_comb begin
        b_eff = (op == OP_SUB) ? ~b_bit : b_bit;
        r     = 1'b0;
        cout  = cin;
        unique case (op)
            OP_ADD, OP_SUB: begin
                r    = a_bit ^ b_eff ^ cin;
                cout = (a_bit & b_eff) | (a_bit & cin) | (b_eff & cin);
            end
            OP_OR:   r = a_bit | b_bit;
            OP_XOR:  r = a_bit ^ b_bit;
            OP_SHL:  r = a_prev;
            OP_SHR:  r = msb_bit ? fill : a_next;
            default: r = a_bit & b_bit;
        endcase
    end

endmodule

// File: rtl/serial_alu.sv
module serial_alu #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [W-1:0]  acc_in,
    input  logic [W-1:0]  opr_in,
    input  logic          chain_en,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  result,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_n,
    output logic          flag_c
);
    import serial_alu_pkg::*;

    typedef struct packed {
        alu_op_e      op;
        logic [W-1:0] a_sr;
        logic [W-1:0] b_sr;
        logic [W-1:0] res_sr;
        logic         carry;
        logic         c_msb_in;
        logic         a_prev;
        logic         a_lsb;
        logic         fill;
        logic         any_one;
        flags_t       flags;
        logic [W-1:0] result;
    } alu_st_t;

    alu_st_t st_q, st_d;

    logic load, run, msb_bit, fin;
    logic bit_r, bit_cout;
    logic a_next;

    serial_alu_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .run     (run),
        .msb_bit (msb_bit),
        .fin     (fin),
        .busy    (busy),
        .done    (done)
    );

    generate
        if (W > 1) begin : g_next
            assign a_next = st_q.a_sr[1];
        end else begin : g_next1
            assign a_next = 1'b0;
        end
    endgenerate

    serial_alu_bitcell u_cell (
        .op      (st_q.op),
        .a_bit   (st_q.a_sr[0]),
        .b_bit   (st_q.b_sr[0]),
        .a_next  (a_next),
        .a_prev  (st_q.a_prev),
        .cin     (st_q.carry),
        .msb_bit (msb_bit),
        .fill    (st_q.fill),
        .r       (bit_r),
        .cout    (bit_cout)
    );

    always_comb begin
        alu_op_e op_in;
        logic    fill_in;
        st_d  = st_q;
        op_in = alu_op_e'(op);
        if (chain_en)
            fill_in = st_q.flags.c;
        else if (op_in == OP_SHR)
            fill_in = acc_in[W-1];
        else
            fill_in = 1'b0;

        if (load) begin
            st_d.op       = op_in;
            st_d.a_sr     = acc_in;
            st_d.b_sr     = opr_in;
            st_d.res_sr   = '0;
            st_d.carry    = chain_en ? st_q.flags.c : (op_in == OP_SUB);
            st_d.c_msb_in = 1'b0;
            st_d.fill     = fill_in;
            st_d.a_prev   = fill_in;
            st_d.a_lsb    = acc_in[0];
            st_d.any_one  = 1'b0;
        end else if (run) begin
            st_d.res_sr  = {bit_r, st_q.res_sr[W-1:1]};
            st_d.a_sr    = st_q.a_sr >> 1;
            st_d.b_sr    = st_q.b_sr >> 1;
            st_d.a_prev  = st_q.a_sr[0];
            st_d.carry   = bit_cout;
            st_d.any_one = st_q.any_one | bit_r;
            if (msb_bit) st_d.c_msb_in = st_q.carry;
        end else if (fin) begin
            st_d.result  = st_q.res_sr;
            st_d.flags.z = ~st_q.any_one;
            st_d.flags.n = st_q.res_sr[W-1];
            if (is_arith(st_q.op)) begin
                st_d.flags.c = st_q.carry;
                st_d.flags.v = st_q.c_msb_in ^ st_q.carry;
            end else if (is_shift(st_q.op)) begin
                st_d.flags.c = (st_q.op == OP_SHL) ? st_q.a_prev : st_q.a_lsb;
                st_d.flags.v = st_q.res_sr[W-1] ^ st_q.a_prev;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result = st_q.result;
    assign flag_z = st_q.flags.z;
    assign flag_v = st_q.flags.v;
    assign flag_n = st_q.flags.n;
    assign flag_c = st_q.flags.c;

endmodule

// File: rtl/serial_alu_checker.sv
module serial_alu_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   op,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_v,
    input logic         flag_n,
    input logic         flag_c
);
    localparam int FRAME = W + 2;
    localparam int FCW   = $clog2(FRAME + 1);

    logic [FCW-1:0] frame_q;
    logic           logic_op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q    <= '0;
            logic_op_q <= 1'b0;
        end else if (start && !busy) begin
            frame_q    <= FCW'(1);
            logic_op_q <= (op == 3'd2) || (op == 3'd3) || (op == 3'd4) || (op == 3'd7);
        end else if (done) begin
            frame_q    <= '0;
        end else if (frame_q != '0) begin
            frame_q    <= frame_q + 1'b1;
        end
    end

    // R2: done appears exactly at the end of the frame, and only then
    a_r2_done_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (frame_q == FCW'(FRAME)));
    a_r2_frame_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_q == FCW'(FRAME)) |-> done);
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
    // R5: negative and zero agree with the result
    a_r5_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((flag_z == (result == '0)) && (flag_n == result[W-1])));
    // R7: logical operations keep carry and overflow
    a_r7_logic_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (done && logic_op_q) |-> (flag_c == $past(flag_c) && flag_v == $past(flag_v)));
    // R8: outputs move only with done
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({result, flag_z, flag_v, flag_n, flag_c}));

endmodule

bind serial_alu serial_alu_checker #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .busy   (busy),
    .done   (done),
    .result (result),
    .flag_z (flag_z),
    .flag_v (flag_v),
    .flag_n (flag_n),
    .flag_c (flag_c)
);

// File: tb/serial_alu_bench.sv
`timescale 1ns/1ps
module serial_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] acc_in = '0;
    logic [15:0] opr_in = '0;
    logic        chain_en = 1'b0;
    logic        busy, done;
    logic [15:0] result;
    logic        flag_z, flag_v, flag_n, flag_c;

    always #2.5 clk = ~clk;

    serial_alu u_serial_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .acc_in(acc_in), .opr_in(opr_in), .chain_en(chain_en),
        .busy(busy), .done(done), .result(result),
        .flag_z(flag_z), .flag_v(flag_v), .flag_n(flag_n), .flag_c(flag_c)
    );

    typedef struct {
        logic [15:0] res;
        logic [3:0]  zvnc;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic m_c = 1'b0;
    logic m_v = 1'b0;
    bit   finished = 1'b0;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Independent reference built from R1, R3, R4, R5, R6, R7
    task automatic model(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                         input logic ml, output exp_t e);
        logic [16:0] s;
        logic [15:0] r;
        logic        c, v, fill;
        c = m_c;
        v = m_v;
        case (o)
            3'd0: begin
                s = {1'b0, a} + {1'b0, b} + 17'(ml ? m_c : 1'b0);
                r = s[15:0]; c = s[16];
                v = (a[15] == b[15]) && (r[15] != a[15]);
            end
            3'd1: begin
                s = {1'b0, a} + {1'b0, ~b} + 17'(ml ? m_c : 1'b1);
                r = s[15:0]; c = s[16];
                v = (a[15] != b[15]) && (r[15] != a[15]);
            end
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: begin
                fill = ml ? m_c : 1'b0;
                r = {a[14:0], fill}; c = a[15]; v = r[15] ^ a[15];
            end
            3'd6: begin
                fill = ml ? m_c : a[15];
                r = {fill, a[15:1]}; c = a[0]; v = r[15] ^ a[15];
            end
            default: r = a & b;
        endcase
        m_c = c;
        m_v = v;
        e.res  = r;
        e.zvnc = {(r == 16'h0), v, r[15], c};
    endtask

    task automatic run_op(input logic [2:0] o, input logic [15:0] a, input logic [15:0] b,
                          input logic ml, input string tag, input bit poke_busy = 1'b0);
        exp_t e;
        int   n;
        @(negedge clk);
        while (busy || done) @(negedge clk);
        model(o, a, b, ml, e);
        e.tag = tag;
        q.push_back(e);
        op = o; acc_in = a; opr_in = b; chain_en = ml; start = 1'b1;
        @(negedge clk);
        n = 1;
        if (poke_busy) begin
            check(busy == 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
            op = 3'd0; acc_in = 16'h1111; opr_in = 16'h2222; chain_en = 1'b0;
            repeat (3) begin @(negedge clk); n++; end
        end
        start = 1'b0;
        while (!done) begin @(negedge clk); n++; end
        check(n == 18, "R2", {"latency ", tag}, 32'(n), 32'd18);
    endtask

    // Monitor: pops an expectation for every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                check(1'b0, "R8", "unexpected done", 32'(result), 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(result == e.res, e.tag, "result", 32'(result), 32'(e.res));
                check({flag_z, flag_v, flag_n, flag_c} == e.zvnc, e.tag, "flags zvnc",
                      32'({flag_z, flag_v, flag_n, flag_c}), 32'(e.zvnc));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R2", "watchdog expired", 32'(q.size()), 32'h0);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check({result, flag_z, flag_v, flag_n, flag_c, busy, done} == '0, "R9", "reset state",
              32'({result, flag_z, flag_v, flag_n, flag_c, busy, done}), 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(3'd0, 16'h1234, 16'h4321, 1'b0, "R1 add");
        run_op(3'd0, 16'h7FFF, 16'h0001, 1'b0, "R4 add overflow");
        run_op(3'd0, 16'hFFFF, 16'h0001, 1'b0, "R3 add carry zero");
        run_op(3'd1, 16'h0005, 16'h0007, 1'b0, "R3 sub borrow");
        run_op(3'd1, 16'h8000, 16'h0001, 1'b0, "R4 sub overflow");
        run_op(3'd1, 16'h0007, 16'h0007, 1'b0, "R5 sub zero");
        run_op(3'd2, 16'hF0F0, 16'h3C3C, 1'b0, "R7 and keeps cv");
        run_op(3'd3, 16'h8001, 16'h0100, 1'b0, "R1 or");
        run_op(3'd4, 16'hA5A5, 16'hA5A5, 1'b0, "R5 xor zero");
        run_op(3'd5, 16'h4000, 16'h0000, 1'b0, "R4 shl overflow");
        run_op(3'd5, 16'h8001, 16'h0000, 1'b0, "R3 shl carry");
        run_op(3'd6, 16'h8001, 16'h0000, 1'b0, "R6 shr sign fill");
        run_op(3'd7, 16'h00FF, 16'h0F0F, 1'b0, "R1 code7 and");
        // chained operations: R6
        run_op(3'd0, 16'hFFFF, 16'h0001, 1'b0, "R6 setup carry");
        run_op(3'd0, 16'h0000, 16'h0000, 1'b1, "R6 add chained");
        run_op(3'd1, 16'h0000, 16'h0001, 1'b0, "R6 sub setup borrow");
        run_op(3'd1, 16'h0005, 16'h0002, 1'b1, "R6 sub chained");
        run_op(3'd5, 16'h0001, 16'h0000, 1'b1, "R6 shl chained");
        run_op(3'd6, 16'h8002, 16'h0000, 1'b1, "R6 shr chained");
        // R8: start while busy ignored
        run_op(3'd4, 16'h1357, 16'h2468, 1'b0, "R8 start ignored", 1'b1);
        begin
            logic [19:0] snap;
            snap = {result, flag_z, flag_v, flag_n, flag_c};
            repeat (6) @(negedge clk);
            check({result, flag_z, flag_v, flag_n, flag_c} == snap, "R8", "hold while idle",
                  32'({result, flag_z, flag_v, flag_n, flag_c}), 32'(snap));
        end
        check(q.size() == 0, "R8", "queue drained", 32'(q.size()), 32'h0);
        finished = 1'b1;
        summary();
    end

endmodule